// File: doc/BRIEF.md
# Self-Timed Asynchronous Serial Receiver

This block receives 8N1 asynchronous serial characters without being given the bit rate. A run meter times every stretch of constant line level in system clocks and keeps the shortest run it has seen as the bit-period estimate. The estimate only ever shrinks, until a clear strobe sets it back to "unknown". Once an estimate exists, each falling edge on an idle line opens a frame. The receiver samples the start bit, eight data bits (least significant first) and the stop bit, each in the middle of its cell. Any line edge inside a frame re-times the cell, so a sender whose clock is a few percent off is still decoded.

The line passes through a synchroniser before any edge is detected. A good character appears on the data output with a one-cycle valid pulse. A low stop bit gives a one-cycle framing-error pulse instead and the character is dropped. A lock flag tells the consumer that a run of clean frames has been decoded with the present estimate.

Top module: `uart_autobaud_rx`

## Requirements
- R1: After reset the period output is all ones (the "no estimate" code), the locked flag is 0 and neither the valid nor the error pulse is asserted.
- R2: The period output equals the shortest line run, counted in system clocks, that has been seen since reset or the last clear. A run is the number of clocks between two consecutive synchronised edges.
- R3: Runs shorter than MIN_RUN clocks (default 8) never change the estimate. A valid estimate is therefore never below MIN_RUN.
- R4: The estimate never grows except through the clear strobe. A clear sets the period output to all ones on the next clock.
- R5: While the estimate is all ones, a falling edge does not start a frame, and no valid or error pulse results from it.
- R6: A frame is a low start bit, 8 data bits sent LSB first, and a stop bit, each sampled at mid-cell. When the stop bit is high, data_o carries the byte and data_vld_o is high for exactly one clock.
- R7: A stop bit sampled low gives a one-clock frame_err_o pulse and no valid pulse for that frame.
- R8: Every line edge inside a frame restarts the cell timing. An edge that comes after the current cell's sample point opens the next cell. A sender whose bit period is about 9% longer than the estimate is still decoded correctly.
- R9: locked_o rises after LOCK_FRAMES (default 4) good frames with no change of the estimate in between. A framing error, a change of estimate or a clear drops it. It is never high while the estimate is all ones.
- R10: A start bit that reads high at its mid-cell sample is treated as noise: the frame is abandoned with no pulse, and the receiver waits for the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Raw serial line, idle high |
| clr_est_i | input | 1 | Discard the period estimate and abandon any frame |
| data_o | output | DATA_BITS | Last good received byte |
| data_vld_o | output | 1 | One-clock pulse with a good byte |
| frame_err_o | output | 1 | One-clock pulse when a stop bit reads low |
| locked_o | output | 1 | Enough clean frames with the present estimate |
| period_o | output | CNT_W | Bit-period estimate in clocks, all ones when none |

## Verification
A wrong run count or a bad minimum update shows at once on period_o, a few clocks after the edge that ends the run. A wrong cell timer or bit index shows up one character later, as a wrong byte, a missing valid pulse or a false framing error. A resync that is missing or misjudged only shows when the sender's period differs from the estimate, so the bench decodes characters sent with a stretched period. A lock counter that counts the wrong events shows on locked_o after the third or fourth frame, or when it stays high across a framing error.

// File: rtl/uab_pkg.sv
package uab_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;
endpackage

// File: rtl/uab_sync.sv
// Input synchroniser chain plus edge detection on the settled line.
module uab_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_i,
   output logic line_o,
   output logic edge_o,
   output logic fall_o
);
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-1:0], rx_i};
   end

   assign line_o = chain[STAGES-1];
   assign edge_o = chain[STAGES-1] ^ chain[STAGES];
   assign fall_o = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/uab_run_meter.sv
// Times each constant-level run and keeps the shortest valid one.
module uab_run_meter #(
   parameter int unsigned CNT_W   = 20,
   parameter int unsigned MIN_RUN = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] period_o,
   output logic             valid_o,
   output logic             upd_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] MIN_L   = CNT_W'(MIN_RUN);

   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] est_q;

   assign upd_o = edge_i && !clr_i && (run_q >= MIN_L) && (run_q < est_q);

   // The run before the first edge is of unknown length: start saturated.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run_q <= CNT_MAX;
      else if (edge_i)         run_q <= CNT_W'(1);
      else if (run_q != CNT_MAX) run_q <= run_q + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      est_q <= CNT_MAX;
      else if (clr_i)  est_q <= CNT_MAX;
      else if (upd_o)  est_q <= run_q;
   end

   assign period_o = est_q;
   assign valid_o  = (est_q != CNT_MAX);
endmodule

// File: rtl/uab_frame_rx.sv
// Frame sequencer: mid-cell sampling with re-timing on every edge.
module uab_frame_rx
   import uab_pkg::*;
#(
   parameter int unsigned CNT_W     = 20,
   parameter int unsigned DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 line_i,
   input  logic                 edge_i,
   input  logic                 fall_i,
   input  logic [CNT_W-1:0]     period_i,
   input  logic                 period_ok_i,
   input  logic                 abort_i,
   output logic [DATA_BITS-1:0] data_o,
   output logic                 vld_o,
   output logic                 ferr_o
);
   localparam int unsigned IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

   rx_state_e            state_q;
   logic [CNT_W-1:0]     tmr_q;
   logic [IDX_W-1:0]     idx_q;
   logic [DATA_BITS-1:0] shift_q;
   logic [CNT_W-1:0]     half;
   logic                 step;
   logic                 smp;

   assign half = period_i >> 1;
   // An edge past the sample point opens the next cell; otherwise the cell restarts.
   assign step = edge_i ? (tmr_q > half) : (tmr_q == period_i - CNT_W'(1));
   assign smp  = !edge_i && (tmr_q == half);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         tmr_q   <= '0;
         idx_q   <= '0;
         shift_q <= '0;
         data_o  <= '0;
         vld_o   <= 1'b0;
         ferr_o  <= 1'b0;
      end else begin
         vld_o  <= 1'b0;
         ferr_o <= 1'b0;
         if (abort_i) begin
            state_q <= RX_IDLE;
         end else if (state_q == RX_IDLE) begin
            if (fall_i && period_ok_i) begin
               state_q <= RX_START;
               tmr_q   <= '0;
               idx_q   <= '0;
            end
         end else begin
            if (edge_i || step) tmr_q <= '0;
            else                tmr_q <= tmr_q + CNT_W'(1);

            if (step) begin
               case (state_q)
                  RX_START: state_q <= RX_DATA;
                  RX_DATA: begin
                     if (idx_q == IDX_LAST) state_q <= RX_STOP;
                     else                   idx_q   <= idx_q + IDX_W'(1);
                  end
                  default: ;
               endcase
            end

            if (smp) begin
               case (state_q)
                  RX_START: if (line_i) state_q <= RX_IDLE;
                  RX_DATA:  shift_q <= {line_i, shift_q[DATA_BITS-1:1]};
                  RX_STOP: begin
                     state_q <= RX_IDLE;
                     if (line_i) begin
                        data_o <= shift_q;
                        vld_o  <= 1'b1;
                     end else begin
                        ferr_o <= 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/uart_autobaud_rx.sv
module uart_autobaud_rx #(
   parameter int unsigned CNT_W       = 20,
   parameter int unsigned MIN_RUN     = 8,
   parameter int unsigned DATA_BITS   = 8,
   parameter int unsigned LOCK_FRAMES = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_i,
   input  logic                 clr_est_i,
   output logic [DATA_BITS-1:0] data_o,
   output logic                 data_vld_o,
   output logic                 frame_err_o,
   output logic                 locked_o,
   output logic [CNT_W-1:0]     period_o
);
   localparam int unsigned LK_W = $clog2(LOCK_FRAMES + 1);
   localparam logic [LK_W-1:0] LK_FULL = LK_W'(LOCK_FRAMES);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MIN_RUN < 4 || MIN_RUN >= (1 << (CNT_W - 1))) begin : g_bad_min
      $error("MIN_RUN out of range for CNT_W");
   end
   if (LOCK_FRAMES < 1) begin : g_bad_lock
      $error("LOCK_FRAMES must be at least 1");
   end

   logic line, edge_s, fall_s;
   logic est_ok, est_upd;
   logic [LK_W-1:0] lk_q;

   uab_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .rx_i   (rx_i),
      .line_o (line),
      .edge_o (edge_s),
      .fall_o (fall_s)
   );

   uab_run_meter #(.CNT_W(CNT_W), .MIN_RUN(MIN_RUN)) i_meter (
      .clk      (clk),
      .rst_n    (rst_n),
      .edge_i   (edge_s),
      .clr_i    (clr_est_i),
      .period_o (period_o),
      .valid_o  (est_ok),
      .upd_o    (est_upd)
   );

   uab_frame_rx #(.CNT_W(CNT_W), .DATA_BITS(DATA_BITS)) i_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_i      (line),
      .edge_i      (edge_s),
      .fall_i      (fall_s),
      .period_i    (period_o),
      .period_ok_i (est_ok),
      .abort_i     (clr_est_i),
      .data_o      (data_o),
      .vld_o       (data_vld_o),
      .ferr_o      (frame_err_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  lk_q <= '0;
      else if (clr_est_i || est_upd || frame_err_o) lk_q <= '0;
      else if (data_vld_o && lk_q != LK_FULL)      lk_q <= lk_q + LK_W'(1);
   end

   assign locked_o = (lk_q == LK_FULL);
endmodule

// File: rtl/uab_rx_chk.sv
module uab_rx_chk #(
   parameter int unsigned CNT_W   = 20,
   parameter int unsigned MIN_RUN = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr_est_i,
   input logic             data_vld_o,
   input logic             frame_err_o,
   input logic             locked_o,
   input logic [CNT_W-1:0] period_o
);
   localparam logic [CNT_W-1:0] NONE = '1;

   // R6
   vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_vld_o |=> !data_vld_o);
   // R7
   ferr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |-> !data_vld_o);
   // R7
   ferr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |=> !frame_err_o);
   // R4
   est_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clr_est_i) |-> period_o <= $past(period_o));
   // R4
   est_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_est_i |=> period_o == NONE);
   // R3
   est_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_o != NONE |-> period_o >= CNT_W'(MIN_RUN));
   // R9
   lock_needs_est_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |-> period_o != NONE);
   // R9
   lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_est_i |=> !locked_o);
endmodule

bind uart_autobaud_rx uab_rx_chk #(.CNT_W(CNT_W), .MIN_RUN(MIN_RUN)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .clr_est_i   (clr_est_i),
   .data_vld_o  (data_vld_o),
   .frame_err_o (frame_err_o),
   .locked_o    (locked_o),
   .period_o    (period_o)
);

// File: tb/test_uart_autobaud_rx.sv
`timescale 1ns/1ps
module test_uart_autobaud_rx;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx = 1'b1;
   logic clr = 1'b0;
   logic [7:0]  data_o;
   logic        data_vld_o, frame_err_o, locked_o;
   logic [19:0] period_o;

   int checks = 0;
   int errors = 0;
   int vld_cnt = 0;
   int ferr_cnt = 0;
   int last_byte = 0;
   int base;

   always #2.5 clk = ~clk;

   uart_autobaud_rx i_uart_autobaud_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_i        (rx),
      .clr_est_i   (clr),
      .data_o      (data_o),
      .data_vld_o  (data_vld_o),
      .frame_err_o (frame_err_o),
      .locked_o    (locked_o),
      .period_o    (period_o)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (data_vld_o) begin
            vld_cnt++;
            last_byte = int'(data_o);
         end
         if (frame_err_o) ferr_cnt++;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic hold(input logic v, input int n);
      rx = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] b, input int p, input logic stop);
      hold(1'b0, p);
      for (int i = 0; i < 8; i++) hold(b[i], p);
      hold(stop, p);
      hold(1'b1, 2 * p);
   endtask

   task automatic pulse_clr();
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 period", int'(period_o), 20'hFFFFF);
      chk("R1 locked", int'(locked_o), 0);
      chk("R1 pulses", vld_cnt + ferr_cnt, 0);

      // R2 estimate from a measured run
      hold(1'b1, 50);
      hold(1'b0, 100);
      hold(1'b1, 200);
      chk("R2 period 100", int'(period_o), 100);

      // R3 glitch run ignored; R10 false start abandoned
      hold(1'b0, 5);
      hold(1'b1, 300);
      chk("R3 glitch ignored", int'(period_o), 100);
      chk("R10 no pulse", vld_cnt + ferr_cnt, 0);

      // R4 shrink, no grow, then clear
      hold(1'b0, 70);
      hold(1'b1, 1500);
      chk("R4 shrink to 70", int'(period_o), 70);
      pulse_clr();
      chk("R4 cleared", int'(period_o), 20'hFFFFF);
      chk("R9 unlocked after clear", int'(locked_o), 0);
      hold(1'b1, 100);
      vld_cnt = 0;
      ferr_cnt = 0;

      // R5 frame whose start edge comes with no estimate
      send(8'hFF, 32, 1'b1);
      chk("R5 no valid", vld_cnt, 0);
      chk("R5 no error", ferr_cnt, 0);
      chk("R2 period 32", int'(period_o), 32);

      // R6 all byte values, R9 lock after the fourth frame
      for (int b = 0; b < 256; b++) begin
         base = vld_cnt;
         send(8'(b), 32, 1'b1);
         chk("R6 one valid", vld_cnt - base, 1);
         chk("R6 byte", last_byte, b);
         if (b == 2) chk("R9 not yet locked", int'(locked_o), 0);
         if (b == 3) chk("R9 locked", int'(locked_o), 1);
      end
      chk("R6 no errors in sweep", ferr_cnt, 0);

      // R7 stop bit low
      base = vld_cnt;
      send(8'hA5, 32, 1'b0);
      chk("R7 error pulse", ferr_cnt, 1);
      chk("R7 no valid", vld_cnt - base, 0);
      chk("R9 lock dropped", int'(locked_o), 0);

      // R8 slow sender (35 clocks per bit against an estimate of 32)
      base = vld_cnt;
      send(8'h5A, 35, 1'b1);
      chk("R8 byte 5A", last_byte, 8'h5A);
      send(8'h33, 35, 1'b1);
      chk("R8 byte 33", last_byte, 8'h33);
      send(8'hC3, 35, 1'b1);
      chk("R8 byte C3", last_byte, 8'hC3);
      chk("R8 count", vld_cnt - base, 3);
      chk("R8 period kept", int'(period_o), 32);
      chk("R9 three frames", int'(locked_o), 0);
      send(8'h81, 32, 1'b1);
      chk("R9 relocked", int'(locked_o), 1);

      pulse_clr();
      chk("R4 final clear", int'(period_o), 20'hFFFFF);
      chk("R9 final unlock", int'(locked_o), 0);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule